// File: doc/BRIEF.md
# Buffered 8-bit Timer with Status Flags

This block is an 8-bit up-counter with a double-buffered period and two channels that can each work as compare or capture. Software loads new period and compare values into buffer registers. When the counter wraps, the buffered values are copied into the active registers, unless a lock bit is set to hold them back. A channel in capture mode latches the current count into its buffer when its external strobe fires.

A status register shows which buffers hold a value that has not yet been consumed, and whether the counter is stopped. The valid flags clear in one of three ways:
- by a hardware transfer on wrap;
- by a write-one-to-clear that only works while the lock bit is set;
- for a capture channel, by reading that channel.

A one-shot mode stops the counter at zero after its first wrap. The host reaches every register through a single read/write port with an address and a read strobe.

Top module: `tmr8_status`

## Requirements
- R1: After reset the status register reads 0x01, the control register and the count read 0x00, and the active and buffered period both read 0xFF.
- R2: Register addresses are as follows; every other address reads 0x00.
  - 0: control, read/write. Bit 0 is enable, bit 1 is one-shot, bit 2 is lock, bit 3 is channel 0 capture mode and bit 4 is channel 1 capture mode.
  - 1: command, write-only, reads 0x00. Bit 0 is start and bit 1 is stop.
  - 2: status. Bit 0 is the stop flag, bit 3 is period-buffer valid, bit 4 is channel 0 buffer valid and bit 5 is channel 1 buffer valid. Bits 7, 6, 2 and 1 always read 0.
  - 3: count.
  - 4: active period.
  - 5: period buffer.
  - 6 and 7: channel 0 and channel 1.
  - 8 and 9: channel 0 buffer and channel 1 buffer.
- R3: While the counter is enabled and the stop flag is 0, the count increases by one per cycle. When the count equals the active period it wraps to 0, and this wrap is the update event. While the stop flag is 1 the count holds.
- R4: The stop flag is forced to 1 in every cycle that follows a cycle with enable at 0, and by a stop command. A start command clears it only when enable is 1 and no stop command is given in the same write.
- R5: With one-shot set, the update event also sets the stop flag, so the count stays at 0.
- R6: A write to the period buffer sets period-buffer valid. On an update event with lock at 0, a valid period buffer is copied into the active period and the flag clears.
- R7: While lock is 1, an update event copies nothing and leaves all valid flags as they are.
- R8: Writing 1 to status bits 5 to 3 clears the matching flag only when lock is 1. This applies to the period flag and to flags of compare channels. Writing 0 has no effect, and so does any write while lock is 0.
- R9: In compare mode, a write to a channel buffer sets its valid flag. On an update event with lock at 0, a valid buffer is copied into the channel and the flag clears.
- R10: In capture mode, the channel's strobe stores the count into the channel buffer and sets its valid flag. Writes to that buffer are ignored. Reading the channel address returns the buffer and clears the flag. Update events and write-one-to-clear leave the flag unchanged.
- R11: When a flag is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| cap | input | 2 | Capture strobes, one per channel |
| rdata | output | 8 | Read data for addr, combinational |

## Verification
Two pairs of functions can fall in the same cycle.

- A software write to the period or compare buffer can coincide with the update event that clears that buffer's flag. The bench provokes this by using its own model to find the cycle in which the count equals the period, and writing the buffer in exactly that cycle. It then expects the old buffer value to be transferred while the flag stays set.
- A capture strobe can coincide with a read of the same channel. The bench drives both together and expects the flag to remain 1.

Random traffic with short periods produces many further collisions. Each one is judged against the bench's model of the flag rules.

// File: rtl/tmr8_status.sv
module tmr8_status #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [3:0]   addr,
  input  logic [W-1:0] wdata,
  input  logic [1:0]   cap,
  output logic [W-1:0] rdata
);

  logic         en, oneshot, lock;
  logic [1:0]   capm;
  logic         stop, pbv;
  logic [1:0]   cv;
  logic [W-1:0] cnt, per, pbuf;
  logic [W-1:0] cc [2];
  logic [W-1:0] cbuf [2];

  wire wr_ctrl = wr_en && addr == 4'd0;
  wire wr_cmd  = wr_en && addr == 4'd1;
  wire wr_stat = wr_en && addr == 4'd2;
  wire wr_pbuf = wr_en && addr == 4'd5;
  wire [1:0] wr_cbuf = {wr_en && addr == 4'd9, wr_en && addr == 4'd8};
  wire [1:0] rd_ch   = {rd_en && addr == 4'd7, rd_en && addr == 4'd6};

  wire run  = en && !stop;
  wire wrap = run && cnt == per;
  wire upd  = wrap && !lock;
  wire [2:0] w1c = (wr_stat && lock) ? wdata[5:3] : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; oneshot <= 1'b0; lock <= 1'b0; capm <= 2'b00;
    end else if (wr_ctrl) begin
      en <= wdata[0]; oneshot <= wdata[1]; lock <= wdata[2]; capm <= wdata[4:3];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stop <= 1'b1;
    else if (!en || (wr_cmd && wdata[1]) || (wrap && oneshot)) stop <= 1'b1;
    else if (wr_cmd && wdata[0]) stop <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (wrap) cnt <= '0;
    else if (run) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per <= '1; pbuf <= '1; pbv <= 1'b0;
    end else begin
      if (upd && pbv) per <= pbuf;
      if (wr_pbuf) pbuf <= wdata;
      pbv <= wr_pbuf || (pbv && !(upd || w1c[0]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cv <= 2'b00;
      for (int i = 0; i < 2; i++) begin
        cc[i] <= '0; cbuf[i] <= '0;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (capm[i]) begin
          if (cap[i]) cbuf[i] <= cnt;
          cv[i] <= cap[i] || (cv[i] && !rd_ch[i]);
        end else begin
          if (wr_cbuf[i]) cbuf[i] <= wdata;
          if (upd && cv[i]) cc[i] <= cbuf[i];
          cv[i] <= wr_cbuf[i] || (cv[i] && !(upd || w1c[i+1]));
        end
      end
    end
  end

  always_comb begin
    case (addr)
      4'd0:    rdata = {3'b000, capm, lock, oneshot, en};
      4'd2:    rdata = {2'b00, cv, pbv, 2'b00, stop};
      4'd3:    rdata = cnt;
      4'd4:    rdata = per;
      4'd5:    rdata = pbuf;
      4'd6:    rdata = capm[0] ? cbuf[0] : cc[0];
      4'd7:    rdata = capm[1] ? cbuf[1] : cc[1];
      4'd8:    rdata = cbuf[0];
      4'd9:    rdata = cbuf[1];
      default: rdata = '0;
    endcase
  end

  AST_STATUS_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    addr == 4'd2 |-> (rdata[7:6] == 2'b00 && rdata[2:1] == 2'b00)); // R2
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> $stable(cnt)); // R3
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt == '0); // R3
  AST_DISABLED_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> stop); // R4
  AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && oneshot) |=> (stop && cnt == '0)); // R5
  AST_LOCK_PER: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(per)); // R7
  AST_PBUF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pbuf |=> pbv); // R11

endmodule

// File: tb/tmr8_status_tb.sv
module tmr8_status_tb;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [1:0] cap = '0;
  logic [7:0] rdata;
  int nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  tmr8_status u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .cap(cap), .rdata(rdata));

  logic m_en, m_os, m_lk, m_stop, m_pv;
  logic [1:0] m_cm, m_cv;
  logic [7:0] m_cnt, m_per, m_pb;
  logic [7:0] m_cc [2];
  logic [7:0] m_cb [2];

  task automatic m_reset();
    m_en = 0; m_os = 0; m_lk = 0; m_cm = 0; m_stop = 1; m_pv = 0; m_cv = 0;
    m_cnt = 0; m_per = 8'hFF; m_pb = 8'hFF;
    for (int i = 0; i < 2; i++) begin m_cc[i] = 0; m_cb[i] = 0; end
  endtask

  function automatic logic [7:0] m_read(input logic [3:0] a);
    case (a)
      0: return {3'b0, m_cm, m_lk, m_os, m_en};
      2: return {2'b0, m_cv, m_pv, 2'b0, m_stop};
      3: return m_cnt;
      4: return m_per;
      5: return m_pb;
      6: return m_cm[0] ? m_cb[0] : m_cc[0];
      7: return m_cm[1] ? m_cb[1] : m_cc[1];
      8: return m_cb[0];
      9: return m_cb[1];
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_tick(input logic w, input logic r, input logic [3:0] a,
                        input logic [7:0] d, input logic [1:0] c);
    logic run, wrp, up, n_stop, n_pv;
    logic [2:0] clr;
    logic [1:0] n_cv;
    logic [7:0] n_cnt, n_per;
    logic [7:0] n_cc [2];
    logic [7:0] n_cb [2];
    run = m_en && !m_stop;
    wrp = run && m_cnt == m_per;
    up  = wrp && !m_lk;
    clr = (w && a == 2 && m_lk) ? d[5:3] : 3'b0;
    n_stop = m_stop;
    if (!m_en || (w && a == 1 && d[1]) || (wrp && m_os)) n_stop = 1;
    else if (w && a == 1 && d[0]) n_stop = 0;
    n_cnt = wrp ? 8'h00 : (run ? m_cnt + 8'd1 : m_cnt);
    n_per = (up && m_pv) ? m_pb : m_per;
    n_pv = m_pv;
    if (up || clr[0]) n_pv = 0;
    if (w && a == 5) n_pv = 1;
    n_cv = m_cv;
    for (int i = 0; i < 2; i++) begin
      n_cc[i] = m_cc[i]; n_cb[i] = m_cb[i];
      if (m_cm[i]) begin
        if (r && a == 6 + i) n_cv[i] = 0;
        if (c[i]) begin n_cb[i] = m_cnt; n_cv[i] = 1; end
      end else begin
        if (up && m_cv[i]) n_cc[i] = m_cb[i];
        if (up || clr[i+1]) n_cv[i] = 0;
        if (w && a == 8 + i) begin n_cb[i] = d; n_cv[i] = 1; end
      end
    end
    if (w && a == 0) begin
      m_en = d[0]; m_os = d[1]; m_lk = d[2]; m_cm = d[4:3];
    end
    if (w && a == 5) m_pb = d;
    m_stop = n_stop; m_cnt = n_cnt; m_per = n_per; m_pv = n_pv; m_cv = n_cv;
    for (int i = 0; i < 2; i++) begin m_cc[i] = n_cc[i]; m_cb[i] = n_cb[i]; end
  endtask

  task automatic step(input logic w, input logic r, input logic [3:0] a,
                      input logic [7:0] d, input logic [1:0] c, input string tag);
    logic [7:0] exp;
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d; cap = c;
    #1;
    exp = m_read(a);
    nchk++;
    if (rdata !== exp) begin
      nfail++;
      $display("FAIL %s addr=%0d actual=%02h expected=%02h", tag, a, rdata, exp);
    end
    m_tick(w, r, a, d, c);
    @(posedge clk);
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    step(0, 1, a, 8'h00, 2'b00, tag);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input string tag);
    step(1, 0, a, d, 2'b00, tag);
  endtask

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      0, 1: return "R4";
      2: return "R8";
      3: return "R3";
      4, 5: return "R6";
      6, 7: return "R10";
      8, 9: return "R9";
      default: return "R2";
    endcase
  endfunction

  initial begin
    #800000;
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(2, "R1"); rd(0, "R1"); rd(3, "R1"); rd(4, "R1"); rd(5, "R1");
    rd(12, "R2"); rd(1, "R2");
    wr(0, 8'h01, "R4"); rd(2, "R4");
    wr(5, 8'h03, "R6"); rd(2, "R6");
    wr(8, 8'h22, "R9"); rd(2, "R9");
    wr(1, 8'h01, "R4"); rd(2, "R4");
    for (int k = 0; k < 270; k++) rd(k % 2 ? 3 : 2, "R3");
    rd(4, "R6"); rd(6, "R9");
    wr(5, 8'h05, "R8"); wr(2, 8'h08, "R8"); rd(2, "R8");
    wr(0, 8'h05, "R8"); wr(2, 8'h00, "R8"); rd(2, "R8");
    wr(2, 8'h08, "R8"); rd(2, "R8");
    wr(5, 8'h06, "R7"); wr(9, 8'h44, "R7");
    for (int k = 0; k < 12; k++) rd(k % 2 ? 4 : 2, "R7");
    wr(0, 8'h01, "R6");
    while (m_cnt != m_per) rd(3, "R3");
    wr(5, 8'h02, "R11"); rd(2, "R11"); rd(4, "R11"); rd(7, "R9");
    wr(0, 8'h03, "R5");
    for (int k = 0; k < 10; k++) rd(k % 2 ? 3 : 2, "R5");
    wr(1, 8'h01, "R5"); rd(2, "R5");
    wr(0, 8'h09, "R10");
    step(0, 0, 8, 8'h00, 2'b01, "R10"); rd(8, "R10"); rd(2, "R10");
    wr(8, 8'h77, "R10"); rd(8, "R10");
    wr(0, 8'h0D, "R10"); wr(2, 8'h10, "R10"); rd(2, "R10");
    wr(0, 8'h09, "R10");
    rd(6, "R10"); rd(2, "R10");
    step(0, 0, 3, 8'h00, 2'b01, "R10");
    step(0, 1, 6, 8'h00, 2'b01, "R11"); rd(2, "R11");
    wr(1, 8'h02, "R4"); rd(2, "R4"); rd(3, "R4");
    wr(1, 8'h03, "R4"); rd(2, "R4");
    wr(0, 8'h00, "R4"); wr(1, 8'h01, "R4"); rd(2, "R4");
    wr(0, 8'h01, "R4"); wr(1, 8'h01, "R4"); rd(2, "R4");
    void'($urandom(32'h5EED));
    for (int k = 0; k < 5000; k++) begin
      logic [3:0] a;
      logic w;
      logic [7:0] d;
      logic [1:0] c;
      a = 4'($urandom_range(0, 10));
      w = ($urandom_range(0, 9) < 4);
      d = 8'($urandom);
      if (a == 0) d = {3'b0, d[4:1], ($urandom_range(0, 9) != 0)};
      if (a == 1) d = {6'b0, d[1], ($urandom_range(0, 2) != 0) | d[0]};
      if (a == 5) d = d & 8'h0F;
      c = {($urandom_range(0, 4) == 0), ($urandom_range(0, 4) == 0)};
      step(w, 1'($urandom), a, d, c, tag_of(a));
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule